// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt requests, ranks them by a fixed priority and signals the processor through a single interrupt line. Software reaches it through a byte-wide register port with one address bit, giving an even and an odd register address. At the odd address sits the mask register. The even address accepts the initialization opener and the operational commands. Reads at the even address return either the request register or the in-service register, as software selects.

After an initialization sequence, the block holds three settings: a vector base, a cascade configuration byte and the end-of-interrupt mode. When the processor pulses the acknowledge strobe, the block drives the vector of the winning input on the read data bus for that cycle. It also moves the winning request into service, unless automatic end-of-interrupt is selected. If nothing is eligible when the acknowledge arrives, the block answers with the vector of input 7 and leaves the in-service state untouched. A later specific or non-specific end-of-interrupt command releases an in-service input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFF, the request and in-service registers are 0x00, `intOut` is low, `cascadeCfg` is 0x00 and even-address reads return the request register.
- R2: An even-address write with bit 4 set starts initialization. The following odd-address writes are taken in order as the vector base, then the cascade byte (skipped when bit 1 of the opening word is 1), then the mode word (only when bit 0 of the opening word is 1). Odd-address writes during this sequence do not change the mask register. Once the sequence ends, odd-address writes load the mask again.
- R3: The vector for input n is the vector base plus n, taken modulo 256.
- R4: The cascade byte written during initialization appears on `cascadeCfg` and keeps its value through a later initialization that skips the cascade byte.
- R5: Bit 1 of the mode word selects automatic end-of-interrupt (1), in which an acknowledge leaves the in-service register unchanged. Bit 1 = 0 selects normal end-of-interrupt. Every initialization opener selects normal mode, so normal mode stays in force when the mode word is skipped.
- R6: An odd-address write outside initialization loads the mask, where bit n = 1 disables input n. An odd-address read returns the mask. A masked request never raises `intOut`.
- R7: A rising edge on `irqIn[n]` sets request bit n, whether or not input n is masked. The bit clears when the input goes low before acknowledge, or when the input is acknowledged.
- R8: Priority is fixed, with input 0 highest. `intOut` is high exactly when some unmasked request bit n exists with no in-service bit at index n or lower.
- R9: While `ackStrobe` is high, `rdData` carries the vector of the highest-priority eligible input. At the end of that cycle its request bit clears and, in normal mode, its in-service bit sets.
- R10: An acknowledge with no eligible input returns the vector base plus 7 and changes no in-service bit.
- R11: An even-address write of 0x60 + n (n = 0 to 7) clears in-service bit n only.
- R12: An even-address write of 0x20 clears the lowest-index in-service bit that is set.
- R13: An even-address write of 0x0A makes even-address reads return the request register, and 0x0B makes them return the in-service register. The choice persists until it is changed or an initialization opener resets it to the request register. An even-address write with bits 4 and 1 both clear and bit 3 set leaves the choice unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addrOdd | input | 1 | Register select: 0 = even address, 1 = odd address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; carries the vector while `ackStrobe` is high |
| ackStrobe | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| irqIn | input | 8 | Interrupt request inputs, edge-triggered |
| intOut | output | 1 | Interrupt request to the processor |
| cascadeCfg | output | 8 | Cascade configuration byte from initialization |

## Verification
The hardest states to reach from the ports are nested service and the spurious acknowledge. Nested service means a higher-priority input interrupts while a lower one is still in service, so that two in-service bits are set at once and the two end-of-interrupt commands must pick different bits. The stimulus holds inputs 3 and 5 high and acknowledges input 3. It then raises input 1, acknowledges it, and alternates a non-specific and a specific end-of-interrupt, reading the in-service register back after each one. For the spurious case, the stimulus raises a request until `intOut` rises, drops it before the acknowledge, and then checks both the vector and the unchanged in-service register.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int NUM_IN = 8;
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int DATA_W = 8;

  // bit positions inside an even-address command byte
  localparam int INIT_BIT   = 4;
  localparam int SELECT_BIT = 3;
  localparam int RDSEL_EN   = 1;
  localparam int RDSEL_ISR  = 0;
  // bits of the opening initialization word
  localparam int OPEN_MODE_BIT   = 0;
  localparam int OPEN_SINGLE_BIT = 1;
  // bit of the mode word that picks automatic release
  localparam int MODE_AUTO_BIT = 1;

  // top three bits of an end-of-interrupt command
  localparam logic [2:0] EOI_SPECIFIC = 3'b011;
  localparam logic [2:0] EOI_LOWEST   = 3'b001;

  typedef enum logic [1:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASCADE,
    CFG_MODE
  } cfgState_t;

  typedef struct packed {
    logic             loadMask;
    logic             clrSpecific;
    logic             clrLowest;
    logic [IDX_W-1:0] clrIdx;
  } dpStrobe_t;

endpackage

// File: rtl/irq_prio_cmd.sv
module irq_prio_cmd
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addrOdd,
  input  logic [DATA_W-1:0] wrData,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] vecBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic              autoEoi,
  output logic              readIsr
);

  cfgState_t cfgState;
  logic      wantMode;
  logic      skipCascade;

  logic evenWr, oddWr, isInit, isSelect, isEoi;

  assign evenWr   = wrEn && !addrOdd;
  assign oddWr    = wrEn && addrOdd;
  assign isInit   = evenWr && wrData[INIT_BIT];
  assign isSelect = evenWr && !wrData[INIT_BIT] && wrData[SELECT_BIT];
  assign isEoi    = evenWr && !wrData[INIT_BIT] && !wrData[SELECT_BIT];

  cfgState_t afterBase, afterCascade;
  assign afterCascade = wantMode ? CFG_MODE : CFG_IDLE;
  assign afterBase    = skipCascade ? afterCascade : CFG_CASCADE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgState    <= CFG_IDLE;
      wantMode    <= 1'b0;
      skipCascade <= 1'b0;
      vecBase     <= '0;
      cascadeCfg  <= '0;
      autoEoi     <= 1'b0;
      readIsr     <= 1'b0;
    end else if (isInit) begin
      cfgState    <= CFG_BASE;
      wantMode    <= wrData[OPEN_MODE_BIT];
      skipCascade <= wrData[OPEN_SINGLE_BIT];
      autoEoi     <= 1'b0;
      readIsr     <= 1'b0;
    end else if (oddWr && cfgState != CFG_IDLE) begin
      case (cfgState)
        CFG_BASE: begin
          vecBase  <= wrData;
          cfgState <= afterBase;
        end
        CFG_CASCADE: begin
          cascadeCfg <= wrData;
          cfgState   <= afterCascade;
        end
        CFG_MODE: begin
          autoEoi  <= wrData[MODE_AUTO_BIT];
          cfgState <= CFG_IDLE;
        end
        default: cfgState <= CFG_IDLE;
      endcase
    end else if (isSelect && wrData[RDSEL_EN]) begin
      readIsr <= wrData[RDSEL_ISR];
    end
  end

  always_comb begin
    strb.loadMask    = oddWr && (cfgState == CFG_IDLE);
    strb.clrSpecific = isEoi && (wrData[DATA_W-1 -: 3] == EOI_SPECIFIC);
    strb.clrLowest   = isEoi && (wrData[DATA_W-1 -: 3] == EOI_LOWEST);
    strb.clrIdx      = wrData[IDX_W-1:0];
  end

  AST_OPENER_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    isInit |=> (cfgState == CFG_BASE && !readIsr && !autoEoi)); // R2

  AST_MODE_WORD_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (cfgState == CFG_MODE && oddWr) |=>
      (cfgState == CFG_IDLE && autoEoi == $past(wrData[MODE_AUTO_BIT]))); // R5

  AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !evenWr |=> $stable(readIsr)); // R13

endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              ackStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] vecBase,
  input  logic              autoEoi,
  output logic [NUM_IN-1:0] irr,
  output logic [NUM_IN-1:0] isr,
  output logic [NUM_IN-1:0] imr,
  output logic [DATA_W-1:0] vector,
  output logic              intOut
);

  logic [NUM_IN-1:0] irqPrev;
  logic [NUM_IN-1:0] isrUpTo;
  logic [NUM_IN-1:0] eligible;
  logic [NUM_IN-1:0] grantOneHot;
  logic [IDX_W-1:0]  grantIdx;
  logic              grantValid;
  logic [NUM_IN-1:0] irrNext, isrNext;

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [NUM_IN-1:0] v);
    lowestIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (v[i]) lowestIdx = IDX_W'(i);
    end
  endfunction

  // in-service bit at this index or any higher-priority one
  assign isrUpTo[0] = isr[0];
  for (genvar i = 1; i < NUM_IN; i++) begin : g_upTo
    assign isrUpTo[i] = isrUpTo[i-1] | isr[i];
  end

  assign eligible    = irr & ~imr & ~isrUpTo;
  assign grantValid  = |eligible;
  assign grantOneHot = eligible & (~eligible + NUM_IN'(1));
  assign grantIdx    = lowestIdx(eligible);
  assign intOut      = grantValid;
  assign vector      = vecBase + (grantValid ? DATA_W'(grantIdx) : DATA_W'(NUM_IN - 1));

  always_comb begin
    irrNext = (irr | (irqIn & ~irqPrev)) & irqIn;
    if (ackStrobe && grantValid) irrNext = irrNext & ~grantOneHot;

    isrNext = isr;
    if (strb.clrSpecific) isrNext[strb.clrIdx] = 1'b0;
    if (strb.clrLowest)   isrNext = isrNext & (isrNext - NUM_IN'(1));
    if (ackStrobe && grantValid && !autoEoi) isrNext = isrNext | grantOneHot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr     <= '0;
      isr     <= '0;
      imr     <= '1;
      irqPrev <= '0;
    end else begin
      irr     <= irrNext;
      isr     <= isrNext;
      irqPrev <= irqIn;
      if (strb.loadMask) imr <= wrData[NUM_IN-1:0];
    end
  end

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && grantValid && !autoEoi && !strb.clrSpecific && !strb.clrLowest) |=>
      ((isr & $past(grantOneHot)) != '0)); // R9

  AST_AUTO_NO_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && autoEoi && !strb.clrSpecific && !strb.clrLowest) |=> $stable(isr)); // R5

  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !grantValid && !strb.clrSpecific && !strb.clrLowest) |=> $stable(isr)); // R10

  AST_TOP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    isr[0] |-> !intOut); // R8

  AST_SPECIFIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrSpecific && !ackStrobe) |=> !isr[$past(strb.clrIdx)]); // R11

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addrOdd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ackStrobe,
  input  logic [NUM_IN-1:0] irqIn,
  output logic              intOut,
  output logic [DATA_W-1:0] cascadeCfg
);

  dpStrobe_t         strb;
  logic [DATA_W-1:0] vecBase;
  logic              autoEoi;
  logic              readIsr;
  logic [NUM_IN-1:0] irr, isr, imr;
  logic [DATA_W-1:0] vector;

  irq_prio_cmd u_cmd (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addrOdd    (addrOdd),
    .wrData     (wrData),
    .strb       (strb),
    .vecBase    (vecBase),
    .cascadeCfg (cascadeCfg),
    .autoEoi    (autoEoi),
    .readIsr    (readIsr)
  );

  irq_prio_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .ackStrobe (ackStrobe),
    .wrData    (wrData),
    .strb      (strb),
    .vecBase   (vecBase),
    .autoEoi   (autoEoi),
    .irr       (irr),
    .isr       (isr),
    .imr       (imr),
    .vector    (vector),
    .intOut    (intOut)
  );

  always_comb begin
    if (ackStrobe)    rdData = vector;
    else if (addrOdd) rdData = DATA_W'(imr);
    else if (readIsr) rdData = DATA_W'(isr);
    else              rdData = DATA_W'(irr);
  end

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/100ps
module irq_prio_ctrl_test;

  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, addrOdd = 1'b0, ackStrobe = 1'b0;
  logic [7:0] wrData = 8'h00, irqIn = 8'h00;
  logic [7:0] rdData, cascadeCfg;
  logic       intOut;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addrOdd(addrOdd), .wrData(wrData),
    .rdData(rdData), .ackStrobe(ackStrobe), .irqIn(irqIn), .intOut(intOut),
    .cascadeCfg(cascadeCfg)
  );

  always #2.5 clk = ~clk;

  int    compared = 0, mismatched = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  logic [7:0] mIrr, mIsr, mImr, mPrev, mBase, mCasc;
  bit         mAuto, mRdIsr, mWantMode, mSkipCasc;
  int         mPhase;

  function automatic int mWinner();
    for (int n = 0; n < 8; n++) begin
      if (mIsr[n]) return -1;
      if (mIrr[n] && !mImr[n]) return n;
    end
    return -1;
  endfunction

  function automatic logic [7:0] mRead();
    int w;
    w = mWinner();
    if (ackStrobe) return (w >= 0) ? 8'((int'(mBase) + w) % 256) : 8'((int'(mBase) + 7) % 256);
    if (addrOdd) return mImr;
    return mRdIsr ? mIsr : mIrr;
  endfunction

  always @(posedge clk) begin
    int w;
    logic [7:0] nIrr, nIsr;
    if (!rstN) begin
      mIrr = 8'h00; mIsr = 8'h00; mImr = 8'hFF; mPrev = 8'h00; mBase = 8'h00; mCasc = 8'h00;
      mAuto = 0; mRdIsr = 0; mWantMode = 0; mSkipCasc = 0; mPhase = 0;
    end else begin
      w = mWinner();
      for (int n = 0; n < 8; n++) begin
        nIrr[n] = (mIrr[n] || (irqIn[n] && !mPrev[n])) && irqIn[n];
        if (ackStrobe && w == n) nIrr[n] = 1'b0;
      end
      nIsr = mIsr;
      if (wrEn && !addrOdd && !wrData[4] && !wrData[3]) begin
        if (wrData[7:5] == 3'd3) nIsr[wrData[2:0]] = 1'b0;
        else if (wrData[7:5] == 3'd1) begin
          for (int n = 0; n < 8; n++) if (nIsr[n]) begin nIsr[n] = 1'b0; break; end
        end
      end
      if (ackStrobe && w >= 0 && !mAuto) nIsr[w] = 1'b1;
      if (wrEn && !addrOdd && wrData[4]) begin
        mPhase = 1; mWantMode = wrData[0]; mSkipCasc = wrData[1]; mAuto = 0; mRdIsr = 0;
      end else if (wrEn && addrOdd) begin
        case (mPhase)
          0: mImr = wrData;
          1: begin mBase = wrData; mPhase = !mSkipCasc ? 2 : (mWantMode ? 3 : 0); end
          2: begin mCasc = wrData; mPhase = mWantMode ? 3 : 0; end
          default: begin mAuto = wrData[1]; mPhase = 0; end
        endcase
      end else if (wrEn && !addrOdd && wrData[3] && wrData[1]) begin
        mRdIsr = wrData[0];
      end
      mIrr = nIrr; mIsr = nIsr; mPrev = irqIn;
    end
  end

  // compare against the reference on every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (intOut !== (mWinner() >= 0) || rdData !== mRead() || cascadeCfg !== mCasc) begin
        mismatched++;
        $display("FAIL %s per-cycle: int=%b exp %b, rd=%h exp %h, casc=%h exp %h",
                 curReq, intOut, (mWinner() >= 0), rdData, mRead(), cascadeCfg, mCasc);
      end
    end
  end

  task automatic expectEq(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit odd, logic [7:0] d);
    wrEn = 1'b1; addrOdd = odd; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(bit odd, logic [7:0] exp, string req);
    addrOdd = odd;
    @(negedge clk);
    expectEq(req, rdData, exp);
    @(posedge clk); #1;
  endtask

  task automatic intChk(bit exp, string req);
    @(negedge clk);
    expectEq(req, {7'b0, intOut}, {7'b0, exp});
    @(posedge clk); #1;
  endtask

  task automatic ackChk(logic [7:0] exp, string req);
    ackStrobe = 1'b1;
    @(negedge clk);
    expectEq(req, rdData, exp);
    @(posedge clk); #1;
    ackStrobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    curReq = "R1";
    rdChk(1, 8'hFF, "R1 mask");
    rdChk(0, 8'h00, "R1 irr");
    intChk(0, "R1 int");
    expectEq("R1 casc", cascadeCfg, 8'h00);

    curReq = "R7";
    irqIn = 8'h02; tick(1);
    intChk(0, "R6 masked input");
    rdChk(0, 8'h02, "R7 edge latched while masked");
    irqIn = 8'h00; tick(1);
    rdChk(0, 8'h00, "R7 level drop clears");

    curReq = "R2";
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    rdChk(1, 8'hFF, "R2 mask untouched by init");
    expectEq("R4 cascade byte", cascadeCfg, 8'h04);
    wr(1, 8'h00);
    rdChk(1, 8'h00, "R6 mask load");

    curReq = "R8";
    irqIn = 8'h28; tick(1);
    intChk(1, "R8 raise");
    ackChk(8'h23, "R3 R9 vector");
    rdChk(0, 8'h20, "R9 irr after ack");
    wr(0, 8'h0B);
    rdChk(0, 8'h08, "R13 isr select");
    intChk(0, "R8 lower blocked");

    curReq = "R12";
    irqIn = 8'h2A; tick(1);
    intChk(1, "R8 nesting");
    ackChk(8'h21, "R9 nested vector");
    rdChk(0, 8'h0A, "R9 two in service");
    wr(0, 8'h20);
    rdChk(0, 8'h08, "R12 lowest cleared");
    intChk(0, "R8 still blocked");

    curReq = "R11";
    wr(0, 8'h63);
    rdChk(0, 8'h00, "R11 specific clear");
    intChk(1, "R8 unblocked");
    ackChk(8'h25, "R9 vector 5");
    rdChk(0, 8'h20, "R9 isr 5");
    wr(0, 8'h65);
    rdChk(0, 8'h00, "R11 clear 5");

    curReq = "R10";
    irqIn = 8'h00; tick(1);
    irqIn = 8'h40; tick(1);
    intChk(1, "R10 raised");
    irqIn = 8'h00; tick(1);
    intChk(0, "R10 dropped");
    ackChk(8'h27, "R10 spurious vector");
    rdChk(0, 8'h00, "R10 isr untouched");

    curReq = "R6";
    wr(1, 8'h10);
    irqIn = 8'h10; tick(1);
    intChk(0, "R6 masked");
    wr(0, 8'h0A);
    rdChk(0, 8'h10, "R13 irr select");
    wr(1, 8'h00);
    intChk(1, "R6 unmasked");
    ackChk(8'h24, "R9 vector 4");
    wr(0, 8'h64);
    irqIn = 8'h00; tick(1);

    curReq = "R5";
    wr(0, 8'h13); wr(1, 8'hFC); wr(1, 8'h03);
    rdChk(1, 8'h00, "R2 mask after short init");
    expectEq("R4 cascade kept", cascadeCfg, 8'h04);
    irqIn = 8'h80; tick(1);
    ackChk(8'h03, "R3 vector wraps");
    wr(0, 8'h0B);
    rdChk(0, 8'h00, "R5 auto release");
    intChk(0, "R5 nothing pending");
    irqIn = 8'h00; tick(1);

    curReq = "R13";
    wr(0, 8'h12); wr(1, 8'h40); wr(1, 8'hFE);
    rdChk(1, 8'hFE, "R2 mask after no-mode init");
    irqIn = 8'h01; tick(1);
    ackChk(8'h40, "R9 vector 0");
    rdChk(0, 8'h00, "R13 opener restores irr select");
    wr(0, 8'h0B);
    rdChk(0, 8'h01, "R5 normal mode default");
    intChk(0, "R8 top in service");
    wr(0, 8'h08);
    rdChk(0, 8'h01, "R13 ignored command");
    irqIn = 8'h00; tick(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule